// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block sits between a host bus and the embedded microcontroller of a legacy-style PC keyboard controller. It passes bytes in both directions. The host writes a byte to one of two write ports, chosen by a single address bit: the data port or the command port. The controller CPU collects that byte from the input buffer and reads a flag that tells it whether the byte is a command or data. In the other direction, the controller CPU writes the output buffer. The host collects that byte through the data read port and polls the status read port.

Two flag state machines track buffer occupancy. The input buffer machine has the states `IB_EMPTY` and `IB_FULL`. Its transitions are `T_HOST_WR` (a host write, from either state, to `IB_FULL`) and `T_CPU_TAKE` (a controller read, `IB_FULL` to `IB_EMPTY`). The output buffer machine has the states `OB_EMPTY` and `OB_FULL`. Its transitions are `T_CPU_FILL` (a controller write, from either state, to `OB_FULL`), `T_HOST_DRAIN` (a host data read while the interrupt mode is gated, `OB_FULL` to `OB_EMPTY`) and `T_SW_CLEAR` (a controller clear strobe, `OB_FULL` to `OB_EMPTY`).

A third machine selects the interrupt mode. It has the states `IRQ_DIRECT` and `IRQ_GATED`, and one transition, `T_ENABLE` (enable strobe, `IRQ_DIRECT` to `IRQ_GATED`). Only reset leaves `IRQ_GATED`. In `IRQ_DIRECT` mode the keyboard interrupt equals a controller port bit. In `IRQ_GATED` mode the interrupt equals OBF AND that port bit.

Top module: `kbc_host_if`

## Requirements
- R1: A host write with `host_addr`=0 stores `host_wdata` in the input buffer. From the next cycle, `cpu_ib_data` shows the byte, IBF is 1 and the command flag is 0.
- R2: A host write with `host_addr`=1 stores the byte in the same way. From the next cycle, IBF is 1 and the command flag (`cpu_cmd_flag`, status bit 3) is 1.
- R3: With `host_addr`=1, `host_rdata` returns the status byte: bit 0 is OBF, bit 1 is IBF, bit 3 is the command flag and all other bits are 0. With `host_addr`=0 it returns the output buffer. A status read changes no flag.
- R4: A controller write (`cpu_ob_wr`) loads `cpu_ob_wdata` into the output buffer and sets OBF. A write while OBF is 1 replaces the byte and OBF stays 1. A write takes priority over any clear in the same cycle.
- R5: `cpu_ib_rd` clears IBF on the next cycle. A host write in the same cycle wins, and IBF stays 1.
- R6: In gated mode, a host data read (`host_rd`=1, `host_addr`=0) clears OBF, and therefore `kbd_irq`, on the next cycle. In gated mode, `kbd_irq` is OBF AND the port bit.
- R7: In direct mode, `kbd_irq` equals the last port bit written with `cpu_p24_wr`, and a host data read leaves OBF unchanged. `cpu_obf_clr` clears OBF in either mode.
- R8: After reset, IBF, OBF, the command flag, the port bit and `kbd_irq` are all 0, and the mode is direct.
- R9: A `cpu_en_flags` pulse selects gated mode, which stays selected until reset. Further pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Port select: 0 data, 1 command/status |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Output buffer or status byte |
| cpu_ib_rd | input | 1 | Controller takes the input buffer |
| cpu_ib_data | output | DATA_W | Input buffer contents |
| cpu_cmd_flag | output | 1 | 1 when the input byte is a command |
| cpu_ob_wr | input | 1 | Controller writes the output buffer |
| cpu_ob_wdata | input | DATA_W | Byte for the output buffer |
| cpu_obf_clr | input | 1 | Controller clears OBF |
| cpu_en_flags | input | 1 | Selects gated interrupt mode |
| cpu_p24_wr | input | 1 | Writes the interrupt port bit |
| cpu_p24_val | input | 1 | Value for the port bit |
| kbd_irq | output | 1 | Keyboard interrupt |

## Verification
A wrong flag state shows at the status port, in the read cycle immediately after the faulty edge. A mode machine stuck in the wrong state shows only when OBF and the port bit differ: the interrupt is then 1 where it should be 0, or the reverse. The bench therefore sweeps every mode, port bit and OBF combination. A lost priority in a same-cycle collision shows one cycle later as a cleared flag. The bench drives each collision explicitly.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    typedef enum logic [0:0] {IB_EMPTY = 1'b0, IB_FULL = 1'b1} ib_state_e;
    typedef enum logic [0:0] {OB_EMPTY = 1'b0, OB_FULL = 1'b1} ob_state_e;
    typedef enum logic [0:0] {IRQ_DIRECT = 1'b0, IRQ_GATED = 1'b1} irq_mode_e;
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
    import kbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cpu_ib_rd,
    output logic [DATA_W-1:0] ib_data,
    output logic              ibf,
    output logic              cd
);
    ib_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic cd_q;

    // next-state: host write (T_HOST_WR) beats controller take (T_CPU_TAKE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IB_EMPTY: if (host_wr) state_d = IB_FULL;
            IB_FULL: begin
                if (host_wr)        state_d = IB_FULL;
                else if (cpu_ib_rd) state_d = IB_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cd_q   <= 1'b0;
        end else if (host_wr) begin
            data_q <= host_wdata;
            cd_q   <= host_addr;
        end
    end

    always_comb begin
        ibf     = (state_q == IB_FULL);
        cd      = cd_q;
        ib_data = data_q;
    end
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ob_wr,
    input  logic [DATA_W-1:0] cpu_ob_wdata,
    input  logic              cpu_obf_clr,
    input  logic              host_data_rd,
    input  logic              gated,
    output logic [DATA_W-1:0] ob_data,
    output logic              obf
);
    ob_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic drain;

    always_comb begin
        drain   = (host_data_rd && gated) || cpu_obf_clr;
        state_d = state_q;
        unique case (state_q)
            OB_EMPTY: if (cpu_ob_wr) state_d = OB_FULL;
            OB_FULL: begin
                if (cpu_ob_wr)  state_d = OB_FULL;
                else if (drain) state_d = OB_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cpu_ob_wr) begin
            data_q <= cpu_ob_wdata;
        end
    end

    always_comb begin
        obf     = (state_q == OB_FULL);
        ob_data = data_q;
    end
endmodule

// File: rtl/kbc_irq_ctl.sv
module kbc_irq_ctl
    import kbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_en_flags,
    input  logic cpu_p24_wr,
    input  logic cpu_p24_val,
    input  logic obf,
    output logic gated,
    output logic irq
);
    irq_mode_e mode_q, mode_d;
    logic p24_q;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            IRQ_DIRECT: if (cpu_en_flags) mode_d = IRQ_GATED;
            IRQ_GATED:  mode_d = IRQ_GATED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= IRQ_DIRECT;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p24_q <= 1'b0;
        end else if (cpu_p24_wr) begin
            p24_q <= cpu_p24_val;
        end
    end

    always_comb begin
        gated = (mode_q == IRQ_GATED);
        unique case (mode_q)
            IRQ_DIRECT: irq = p24_q;
            IRQ_GATED:  irq = p24_q & obf;
        endcase
    end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if #(
    parameter int DATA_W  = 8,
    parameter int OBF_BIT = 0,
    parameter int IBF_BIT = 1,
    parameter int CD_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cpu_ib_rd,
    output logic [DATA_W-1:0] cpu_ib_data,
    output logic              cpu_cmd_flag,
    input  logic              cpu_ob_wr,
    input  logic [DATA_W-1:0] cpu_ob_wdata,
    input  logic              cpu_obf_clr,
    input  logic              cpu_en_flags,
    input  logic              cpu_p24_wr,
    input  logic              cpu_p24_val,
    output logic              kbd_irq
);
    localparam int STAT_W = DATA_W;

    logic              obf_w, ibf_w, cd_w, gated_w;
    logic              host_data_rd;
    logic [DATA_W-1:0] ob_data_w;
    logic [STAT_W-1:0] status_w;

    assign host_data_rd = host_rd && !host_addr;

    kbc_in_buf #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .cpu_ib_rd(cpu_ib_rd),
        .ib_data(cpu_ib_data), .ibf(ibf_w), .cd(cd_w)
    );

    kbc_out_buf #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cpu_ob_wr(cpu_ob_wr),
        .cpu_ob_wdata(cpu_ob_wdata), .cpu_obf_clr(cpu_obf_clr),
        .host_data_rd(host_data_rd), .gated(gated_w),
        .ob_data(ob_data_w), .obf(obf_w)
    );

    kbc_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .cpu_en_flags(cpu_en_flags),
        .cpu_p24_wr(cpu_p24_wr), .cpu_p24_val(cpu_p24_val),
        .obf(obf_w), .gated(gated_w), .irq(kbd_irq)
    );

    always_comb begin
        status_w          = '0;
        status_w[OBF_BIT] = obf_w;
        status_w[IBF_BIT] = ibf_w;
        status_w[CD_BIT]  = cd_w;
    end

    assign host_rdata   = host_addr ? status_w : ob_data_w;
    assign cpu_cmd_flag = cd_w;
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic host_rd,
    input logic host_addr,
    input logic cpu_ib_rd,
    input logic cpu_ob_wr,
    input logic cpu_obf_clr,
    input logic obf,
    input logic ibf,
    input logic cd,
    input logic gated,
    input logic kbd_irq
);
    p_ibf_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf);
    p_cd_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> cd == $past(host_addr));
    p_obf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ob_wr |=> obf);
    p_ibf_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ib_rd && !host_wr) |=> !ibf);
    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && host_rd && !host_addr && !cpu_ob_wr) |=> (!obf && !kbd_irq));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gated && obf && !cpu_obf_clr) |=> obf);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gated |=> gated);
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .cpu_ib_rd(cpu_ib_rd), .cpu_ob_wr(cpu_ob_wr),
    .cpu_obf_clr(cpu_obf_clr), .obf(obf_w), .ibf(ibf_w), .cd(cd_w),
    .gated(gated_w), .kbd_irq(kbd_irq)
);

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       cpu_ib_rd = 0;
    logic [7:0] cpu_ib_data;
    logic       cpu_cmd_flag;
    logic       cpu_ob_wr = 0;
    logic [7:0] cpu_ob_wdata = 0;
    logic       cpu_obf_clr = 0, cpu_en_flags = 0, cpu_p24_wr = 0, cpu_p24_val = 0;
    logic       kbd_irq;

    int checks = 0, failures = 0;
    logic m_obf = 0, m_ibf = 0, m_cd = 0, m_gated = 0, m_p24 = 0;
    logic [7:0] m_ob = 0, m_ib = 0;
    logic [7:0] seen_rdata;

    always #4 clk = ~clk;

    kbc_host_if uut (.*);

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {4'b0, m_cd, 1'b0, m_ibf, m_obf};
    endfunction

    function automatic logic exp_irq();
        return m_gated ? (m_p24 & m_obf) : m_p24;
    endfunction

    // one cycle of stimulus; model updated from the requirements
    task automatic cyc(input logic wr, input logic rd, input logic addr, input logic [7:0] wd,
                       input logic ibrd, input logic obwr, input logic [7:0] obd,
                       input logic obclr, input logic en, input logic pwr, input logic pv);
        host_wr = wr; host_rd = rd; host_addr = addr; host_wdata = wd;
        cpu_ib_rd = ibrd; cpu_ob_wr = obwr; cpu_ob_wdata = obd;
        cpu_obf_clr = obclr; cpu_en_flags = en; cpu_p24_wr = pwr; cpu_p24_val = pv;
        #1 seen_rdata = host_rdata;
        @(negedge clk);
        if (wr) begin m_ib = wd; m_cd = addr; m_ibf = 1; end
        else if (ibrd) m_ibf = 0;
        if (obwr) begin m_ob = obd; m_obf = 1; end
        else if ((rd && !addr && m_gated) || obclr) m_obf = 0;
        if (en) m_gated = 1;
        if (pwr) m_p24 = pv;
        host_wr = 0; host_rd = 0; cpu_ib_rd = 0; cpu_ob_wr = 0;
        cpu_obf_clr = 0; cpu_en_flags = 0; cpu_p24_wr = 0;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic check_state(input string req);
        host_addr = 1;
        #1;
        chk({req, " status"}, host_rdata, exp_status());
        chk({req, " irq"}, kbd_irq, exp_irq());
        host_addr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        m_obf = 0; m_ibf = 0; m_cd = 0; m_gated = 0; m_p24 = 0; m_ob = 0; m_ib = 0;
    endtask

    initial begin
        do_reset();
        // R8: reset state
        check_state("R8");
        chk("R8 cmd flag", cpu_cmd_flag, 0);

        // R1/R2: sweep all bytes through both write ports
        for (int i = 0; i < 512; i++) begin
            logic [7:0] b;
            b = i[8:1] ^ 8'hA5;
            cyc(1, 0, i[0], b, 0, 0, 0, 0, 0, 0, 0);
            chk(i[0] ? "R2 ib data" : "R1 ib data", cpu_ib_data, b);
            chk(i[0] ? "R2 cmd flag" : "R1 cmd flag", cpu_cmd_flag, i[0]);
            check_state(i[0] ? "R2" : "R1");
            if (i[1]) begin
                cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
                check_state("R5 take");
            end
        end
        // R5: host write and controller take collide
        cyc(1, 0, 0, 8'h3C, 1, 0, 0, 0, 0, 0, 0);
        check_state("R5 collide");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        check_state("R5 clear");

        // R7: direct mode, port bit drives irq
        for (int v = 0; v < 4; v++) begin
            cyc(0, 0, 0, 0, 0, v[1], 8'h50 + 8'(v), 0, 0, 1, v[0]);
            check_state("R7 direct");
        end
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 data port", seen_rdata, m_ob);
        check_state("R7 read keeps obf");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check_state("R7 sw clear");

        // R4: overwrite and write-over-clear priority
        cyc(0, 0, 0, 0, 0, 1, 8'h11, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 8'h22, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 overwrite data", seen_rdata, 8'h22);
        check_state("R4 overwrite");
        cyc(0, 0, 0, 0, 0, 1, 8'h33, 1, 0, 0, 0);
        check_state("R4 write beats clear");

        // R3: status reads have no side effect
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
            chk("R3 status read", seen_rdata, exp_status());
            check_state("R3 no side effect");
        end

        // R6: gated mode sweep over port bit and OBF
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        for (int v = 0; v < 4; v++) begin
            cyc(0, 0, 0, 0, 0, v[1], 8'h60 + 8'(v), !v[1], 0, 1, v[0]);
            check_state("R6 gated");
        end
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 read data", seen_rdata, 8'h63);
        check_state("R6 read drains");
        cyc(0, 0, 0, 0, 0, 1, 8'h77, 0, 0, 0, 0);
        check_state("R6 irq up");
        cyc(0, 1, 0, 0, 0, 1, 8'h78, 0, 0, 0, 0);
        check_state("R4 write beats gated read");

        // R9: mode sticks through more pulses and port writes
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
        check_state("R9 sticky");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        check_state("R9 still gated");

        // R8: reset mid-run returns to direct mode
        do_reset();
        check_state("R8 rerun");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        check_state("R8 direct after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule